// File: doc/BRIEF.md
# Rank Decoder with Spare-Rank Redirect

This block resolves which memory rank a normalized channel address falls in. For the selected memory controller it holds eight rank base words and four rank mask words; each rank compares the address against its base, ignoring the bits its mask sets. The lowest-numbered enabled rank that agrees wins. The result gives a found flag, the rank index and the DIMM index, which is the rank index halved.

A status word reports an online-spare swap for each of two channels. If the swap for the current channel has completed and the winning rank is the one that failed, the result is redirected to the spare rank. The spare rank is the lowest-numbered rank whose base word carries the spare flag. In ganged operation both channels share the rank configuration of controller 0. The result is registered. It appears one cycle after a request is presented.

Top module: `csm_rank_match`

## Requirements
- R1: A rank takes part only when bit 0 (enable) of its base word is 1. A disabled rank never produces a hit, even on an exact match.
- R2: Base, mask and address are each aligned the same way. The address is shifted right by 8, ANDed with the fixed field mask 32'h1FF83FE0, then shifted left by 8. Base and mask are ANDed with the same field mask, then shifted left by 8. A rank agrees when the aligned address and the aligned base are equal in every bit the aligned mask does not set.
- R3: Rank n uses mask word n/2, so ranks 2k and 2k+1 share mask word k.
- R4: When several enabled ranks agree, the lowest index is reported.
- R5: When no rank agrees, hit is 0 and the rank and DIMM indices are 0.
- R6: With ganged set, the base and mask words of controller 0 are used for either channel. Otherwise the controller equals channel_sel.
- R7: For channel c, status bit 1+2c is the swap-done flag and bits [4+4c+2:4+4c] hold the failed rank index. The redirect applies when swap-done is 1 and the agreeing rank equals the failed index. The reported rank then becomes the lowest index in the same controller whose base word bit 1 (spare) is 1. If no rank is flagged spare, the agreeing rank is kept.
- R8: The DIMM index equals the final rank index divided by 2, after any redirect.
- R9: Results are registered. out_valid follows req_valid one cycle later. hit, rank_idx and dimm_idx change only on cycles after req_valid was 1, and otherwise hold. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| chan_addr | input | 48 | Normalized channel address |
| channel_sel | input | 1 | Channel of the request |
| ganged | input | 1 | Use controller 0 configuration for both channels |
| base_words | input | 512 | Rank base words, controller-major, 32 bits each |
| mask_words | input | 256 | Rank mask words, controller-major, 32 bits each |
| spare_status | input | 32 | Spare swap status for both channels |
| out_valid | output | 1 | Result valid |
| hit | output | 1 | A rank decodes the address |
| rank_idx | output | 3 | Final rank index |
| dimm_idx | output | 2 | DIMM index |

## Verification
The hardest case to reach is the redirect. It needs three things at once: the swap-done flag for the request's own channel, a failed-rank field equal to the rank that wins, and a spare-flagged rank in the controller actually in use. Random words almost never line up that way. Directed cases therefore build base words from the target address and write the winning index into the status field of the correct channel, and vary which controller supplies the spare flag. The random phase also derives many base words from the address, with small masked perturbations, so that hits, shared-mask effects and occasional redirects occur often.

// File: rtl/csm_pkg.sv
package csm_pkg;
    localparam int unsigned RANK_IDX_W = 3;
    localparam int unsigned DIMM_IDX_W = 2;

    typedef struct packed {
        logic                  valid;
        logic                  hit;
        logic [RANK_IDX_W-1:0] rank;
        logic [DIMM_IDX_W-1:0] dimm;
    } match_res_t;
endpackage

// File: rtl/csm_rank_cmp.sv
module csm_rank_cmp #(
    parameter int unsigned       WORD_W     = 32,
    parameter logic [WORD_W-1:0] FIELD_MASK = 32'h1FF83FE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] addr_field,
    input  logic [WORD_W-1:0] base_word,
    input  logic [WORD_W-1:0] mask_word,
    output logic              agree
);
    localparam int unsigned ALIGN_W = WORD_W + 8;

    logic [ALIGN_W-1:0] addr_al;
    logic [ALIGN_W-1:0] base_al;
    logic [ALIGN_W-1:0] mask_al;

    always_comb begin
        addr_al = {addr_field & FIELD_MASK, 8'h00};
        base_al = {base_word  & FIELD_MASK, 8'h00};
        mask_al = {mask_word  & FIELD_MASK, 8'h00};
        agree   = base_word[0] && ((addr_al & ~mask_al) == (base_al & ~mask_al));
    end

    // R1: a disabled rank must never agree
    p_agree_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        agree |-> base_word[0]);
endmodule

// File: rtl/csm_first_pick.sv
module csm_first_pick #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    // R4: the picked entry is a requester and nothing lower requested
    p_pick_is_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> req[idx]);
    p_pick_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((req & ((N'(1) << idx) - N'(1))) == '0));
    p_pick_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (!found && idx == '0));
endmodule

// File: rtl/csm_rank_match.sv
module csm_rank_match
    import csm_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 48,
    parameter int unsigned       WORD_W     = 32,
    parameter int unsigned       NUM_RANK   = 8,
    parameter int unsigned       NUM_CTRL   = 2,
    parameter logic [WORD_W-1:0] FIELD_MASK = 32'h1FF83FE0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    input  logic [ADDR_W-1:0]                  chan_addr,
    input  logic                               channel_sel,
    input  logic                               ganged,
    input  logic [NUM_CTRL*NUM_RANK*WORD_W-1:0]   base_words,
    input  logic [NUM_CTRL*NUM_RANK/2*WORD_W-1:0] mask_words,
    input  logic [WORD_W-1:0]                  spare_status,
    output logic                               out_valid,
    output logic                               hit,
    output logic [RANK_IDX_W-1:0]              rank_idx,
    output logic [DIMM_IDX_W-1:0]              dimm_idx
);
    localparam int unsigned NUM_MASK  = NUM_RANK / 2;
    localparam int unsigned FIELD_LO  = 8;
    localparam int unsigned FIELD_HI  = FIELD_LO + WORD_W - 1;
    localparam int unsigned SWAP_BASE = 1;
    localparam int unsigned SWAP_STEP = 2;
    localparam int unsigned BAD_BASE  = 4;
    localparam int unsigned BAD_STEP  = 4;

    logic                  ctrl_sel;
    logic [WORD_W-1:0]     addr_field;
    logic [WORD_W-1:0]     base_sel [NUM_RANK];
    logic [WORD_W-1:0]     mask_sel [NUM_RANK];
    logic [NUM_RANK-1:0]   agree_vec;
    logic [NUM_RANK-1:0]   spare_vec;
    logic                  m_found;
    logic [RANK_IDX_W-1:0] m_idx;
    logic                  s_found;
    logic [RANK_IDX_W-1:0] s_idx;
    logic                  swap_done;
    logic [RANK_IDX_W-1:0] bad_rank;
    logic                  unused_addr_bits;
    match_res_t            res_d;
    match_res_t            res_q;

    assign ctrl_sel         = ganged ? 1'b0 : channel_sel;
    assign addr_field       = chan_addr[FIELD_HI:FIELD_LO];
    assign unused_addr_bits = ^{chan_addr[ADDR_W-1:FIELD_HI+1], chan_addr[FIELD_LO-1:0]};

    for (genvar g = 0; g < NUM_RANK; g++) begin : g_rank
        assign base_sel[g]  = base_words[(int'(ctrl_sel) * NUM_RANK + g) * WORD_W +: WORD_W];
        assign mask_sel[g]  = mask_words[(int'(ctrl_sel) * NUM_MASK + g / 2) * WORD_W +: WORD_W];
        assign spare_vec[g] = base_sel[g][1];

        csm_rank_cmp #(
            .WORD_W     (WORD_W),
            .FIELD_MASK (FIELD_MASK)
        ) u_cmp (
            .clk        (clk),
            .rst_n      (rst_n),
            .addr_field (addr_field),
            .base_word  (base_sel[g]),
            .mask_word  (mask_sel[g]),
            .agree      (agree_vec[g])
        );
    end

    csm_first_pick #(.N(NUM_RANK), .IW(RANK_IDX_W)) u_pick_match (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (agree_vec),
        .found (m_found),
        .idx   (m_idx)
    );

    csm_first_pick #(.N(NUM_RANK), .IW(RANK_IDX_W)) u_pick_spare (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (spare_vec),
        .found (s_found),
        .idx   (s_idx)
    );

    assign swap_done = spare_status[SWAP_BASE + SWAP_STEP * int'(channel_sel)];
    assign bad_rank  = spare_status[BAD_BASE + BAD_STEP * int'(channel_sel) +: RANK_IDX_W];

    always_comb begin
        res_d       = res_q;
        res_d.valid = req_valid;
        if (req_valid) begin
            res_d.hit  = m_found;
            res_d.rank = '0;
            if (m_found) begin
                if (swap_done && (m_idx == bad_rank) && s_found) begin
                    res_d.rank = s_idx;
                end else begin
                    res_d.rank = m_idx;
                end
            end
            res_d.dimm = DIMM_IDX_W'(res_d.rank >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign hit       = res_q.hit;
    assign rank_idx  = res_q.rank;
    assign dimm_idx  = res_q.dimm;

    // R9: one-cycle latency of the valid strobe
    p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(req_valid));
    // R9: outputs hold when no request was presented
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(hit) && $stable(rank_idx) && $stable(dimm_idx)));
    // R5: a miss reports zero indices
    p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !hit) |-> (rank_idx == '0 && dimm_idx == '0));
    // R7: without a completed swap the winner is reported unchanged
    p_no_swap_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && m_found && !swap_done) |=> (rank_idx == $past(m_idx)));
    // R7: a redirect lands on a spare-flagged rank
    p_redirect_spare_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && m_found && swap_done && m_idx == bad_rank && s_found)
            |=> (rank_idx == $past(s_idx)));
endmodule

// File: tb/csm_rank_match_tb_top.sv
module csm_rank_match_tb_top;
    localparam logic [31:0] FMASK = 32'h1FF83FE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [47:0] chan_addr = '0;
    logic        channel_sel = 1'b0;
    logic        ganged = 1'b0;
    logic [31:0] spare_status = '0;
    logic [31:0] bw [2][8];
    logic [31:0] mw [2][4];
    logic [511:0] base_words;
    logic [255:0] mask_words;
    logic        out_valid;
    logic        hit;
    logic [2:0]  rank_idx;
    logic [1:0]  dimm_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 8; r++) base_words[(c*8+r)*32 +: 32] = bw[c][r];
            for (int m = 0; m < 4; m++) mask_words[(c*4+m)*32 +: 32] = mw[c][m];
        end
    end

    csm_rank_match dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .chan_addr(chan_addr),
        .channel_sel(channel_sel), .ganged(ganged), .base_words(base_words),
        .mask_words(mask_words), .spare_status(spare_status), .out_valid(out_valid),
        .hit(hit), .rank_idx(rank_idx), .dimm_idx(dimm_idx)
    );

    // Expected {hit, rank, dimm} from the requirement text
    function automatic logic [5:0] model();
        int c;
        logic [39:0] a, b, m;
        logic f;
        int w, sp;
        bit sw;
        logic [2:0] bad;
        c = ganged ? 0 : int'(channel_sel);
        a = {40'(((chan_addr >> 8) & 48'(FMASK))) << 0} << 8;
        f = 0; w = 0;
        for (int r = 7; r >= 0; r--) begin
            b = {8'h0, bw[c][r] & FMASK} << 8;
            m = {8'h0, mw[c][r/2] & FMASK} << 8;
            if (bw[c][r][0] && ((a & ~m) == (b & ~m))) begin f = 1; w = r; end
        end
        sw  = spare_status[channel_sel ? 3 : 1];
        bad = channel_sel ? spare_status[10:8] : spare_status[6:4];
        sp  = -1;
        for (int r = 7; r >= 0; r--) if (bw[c][r][1]) sp = r;
        if (f && sw && (3'(w) == bad) && sp >= 0) w = sp;
        return {f, 3'(w), 2'(w / 2)};
    endfunction

    task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got v/hit/rank/dimm=%b expected %b", tag, got, exp);
        end
    endtask

    task automatic run_case(input string tag);
        logic [5:0] e;
        @(negedge clk);
        req_valid = 1'b1;
        e = model();
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {out_valid, hit, rank_idx, dimm_idx}, {1'b1, e});
    endtask

    task automatic clear_cfg();
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 8; r++) bw[c][r] = '0;
            for (int m = 0; m < 4; m++) mw[c][m] = '0;
        end
        spare_status = '0;
        ganged = 1'b0;
        channel_sel = 1'b0;
    endtask

    function automatic logic [31:0] fld(input logic [47:0] ad);
        return 32'(ad >> 8) & FMASK;
    endfunction

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] fa;
        logic [6:0] held;
        void'($urandom(32'd4711));
        clear_cfg();
        chan_addr = 48'h0000_1234_5600;
        repeat (3) @(negedge clk);
        check("R9 reset", {out_valid, hit, rank_idx, dimm_idx}, 7'd0);
        rst_n = 1'b1;
        fa = fld(chan_addr);

        // R1 + R5: exact base but enable clear
        bw[0][3] = fa;
        run_case("R1 disabled rank");
        check("R5 miss zero", {out_valid, hit, rank_idx, dimm_idx}, 7'b1_0_000_00);

        // R2 + R8: single enabled rank 5
        clear_cfg(); bw[0][5] = fa | 32'h1;
        run_case("R2 R8 rank5 dimm2");
        check("R8 direct", {hit, rank_idx, dimm_idx}, 6'b1_101_10);
        bw[0][5] = (fa ^ 32'h0000_0020) | 32'h1;
        run_case("R2 differing bit miss");

        // R4: two agreeing ranks
        clear_cfg(); bw[0][2] = fa | 32'h1; bw[0][6] = fa | 32'h1;
        run_case("R4 lowest wins");
        check("R4 direct", {hit, rank_idx}, 4'b1_010);

        // R3: shared mask of ranks 2,3
        clear_cfg();
        bw[0][1] = (fa ^ 32'h20) | 32'h1;
        bw[0][3] = (fa ^ 32'h20) | 32'h1;
        mw[0][1] = 32'h20;
        run_case("R3 shared mask");
        check("R3 direct", {hit, rank_idx, dimm_idx}, 6'b1_011_01);

        // R6: ganged uses controller 0 for channel 1
        clear_cfg(); bw[0][4] = fa | 32'h1; bw[1][1] = fa | 32'h1;
        channel_sel = 1'b1; ganged = 1'b1;
        run_case("R6 ganged ctrl0");
        ganged = 1'b0;
        run_case("R6 unganged ctrl1");
        check("R6 direct", {hit, rank_idx}, 4'b1_001);

        // R7: redirect on channel 1
        clear_cfg(); channel_sel = 1'b1;
        bw[1][2] = fa | 32'h1; bw[1][6] = 32'h2; bw[1][7] = 32'h2; bw[0][0] = 32'h2;
        spare_status = 32'h0000_0208;
        run_case("R7 redirect ch1");
        check("R7 direct", {hit, rank_idx, dimm_idx}, 6'b1_110_11);
        spare_status = 32'h0000_0022;
        run_case("R7 other channel flag");
        bw[1][6] = '0; bw[1][7] = '0; spare_status = 32'h0000_0208;
        run_case("R7 no spare keeps");
        ganged = 1'b1; bw[0][2] = fa | 32'h1; bw[0][5] = 32'h2;
        run_case("R7 ganged spare ctrl0");

        // R9: hold while idle
        held = {out_valid, hit, rank_idx, dimm_idx};
        @(negedge clk);
        chan_addr = 48'h0000_FFFF_0000; clear_cfg();
        @(negedge clk);
        check("R9 hold", {out_valid, hit, rank_idx, dimm_idx}, {1'b0, held[5:0]});

        // Random phase
        for (int it = 0; it < 400; it++) begin
            chan_addr = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            fa = fld(chan_addr);
            ganged = ($urandom % 4) == 0;
            channel_sel = 1'($urandom);
            for (int c = 0; c < 2; c++) begin
                for (int r = 0; r < 8; r++) begin
                    if ($urandom % 2) bw[c][r] = (fa ^ ($urandom & $urandom & $urandom & FMASK)) | 32'(($urandom % 4) != 0);
                    else bw[c][r] = $urandom;
                    if (($urandom % 5) != 0) bw[c][r][1] = 1'b0;
                end
                for (int m = 0; m < 4; m++) mw[c][m] = $urandom & $urandom & $urandom;
            end
            spare_status = $urandom;
            run_case("R2 R3 R4 R6 R7 R8 random");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule